// File: doc/BRIEF.md
# Fixed-OR Sum-of-Products Logic Device

This block is a field-configurable sum-of-products logic engine with a fixed OR plane. Ten dedicated inputs and six pin feedback lines make up a 16-wide array input vector. Every array input appears to every AND term in both true and complemented form, which gives 32 literal lines per term. Each of the eight outputs owns seven product terms that feed its OR gate, plus one more product term that drives that output's enable. Product terms are never shared between outputs.

An output value is the complement of its OR by default. A per-output polarity bit removes that inversion. Outputs 0 to 5 are also looped back into the array. When such a pin is disabled, the externally driven pin value is fed back, so the pin can be used as an input. When the pin is enabled, its own value is fed back. Feedback passes through a register that updates on every clock, so two-pass logic settles one cycle later. Pins are modelled as a separate value and enable pair.

The whole configuration image is shifted in serially. A commit strobe copies it into the active plane. Every enable stays low until the first commit after reset.

Top module: `pal_logic_device`

## Requirements
- R1: After reset, `oe_o` stays all zero until the first cycle in which `cfg_commit_i` is high. The enables follow the configuration from the clock edge that samples that commit.
- R2: Shifting configuration bits with `cfg_shift_i` changes neither `out_o` nor `oe_o` until a commit.
- R3: Term t of output o (t = 0..6 sum terms, t = 7 enable term) has its 32-bit connection mask at image bits `[(o*8+t)*32 +: 32]`. Mask bit 2k selects the true form of array input k, and bit 2k+1 selects its complement. A term is true when every selected literal is 1, and a term with no selected literal is true.
- R4: The polarity bit of output o is image bit 2048+o. When it is 0, `out_o[o]` is the NOT of the OR of its seven sum terms. When it is 1, `out_o[o]` is that OR.
- R5: The sum terms of one output have no effect on any other output.
- R6: `oe_o[o]` equals the enable term of output o once a commit has happened.
- R7: Array inputs 0..9 are `in_i[0..9]`, and array inputs 10..15 are the feedback lines of outputs 0..5.
- R8: On each clock edge, feedback line j (j = 0..5) loads `out_o[j]` if `oe_o[j]` is 1, and `pin_i[j]` otherwise. Outputs react combinationally to `in_i`, and to feedback only after that edge.
- R9: Serial loading sends image bit 2055 first and bit 0 last. A commit copies the last 2056 shifted bits.
- R10: Reset clears the active image, the shift register and the feedback lines. During and after reset, `out_o` and `oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_i | input | 10 | Dedicated logic inputs |
| pin_i | input | 6 | Externally driven value on pins 0..5 |
| cfg_bit_i | input | 1 | Serial configuration data |
| cfg_shift_i | input | 1 | Shift one configuration bit per cycle |
| cfg_commit_i | input | 1 | Copy the shifted image into the active plane |
| out_o | output | 8 | Output pin values |
| oe_o | output | 8 | Output pin enables |

## Verification
Paths from `in_i` to `out_o` and `oe_o` are combinational. The bench therefore checks them 1 ns after driving, inside the same cycle. A result that travels through a feedback line is checked only after the next rising edge. The bench also checks that such a result has not yet moved before that edge. A commit takes effect at the edge that samples it, so the commit checks sample 1 ns after that edge. Table vectors are held for two edges so that feedback chains settle before both outputs are compared.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned PAL_N_IN  = 10;
  localparam int unsigned PAL_N_OUT = 8;
  localparam int unsigned PAL_N_SUM = 7;
  localparam int unsigned PAL_N_FB  = 6;
endpackage

// File: rtl/pal_cfg_loader.sv
module pal_cfg_loader #(
  parameter int unsigned CFG_W = 2056
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             shift_i,
  input  logic             commit_i,
  output logic [CFG_W-1:0] image_o,
  output logic             loaded_o
);
  logic [CFG_W-1:0] sr_q, img_q;
  logic             loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      img_q    <= '0;
      loaded_q <= 1'b0;
    end else begin
      if (shift_i) sr_q <= {sr_q[CFG_W-2:0], bit_i};
      if (commit_i) begin
        img_q    <= sr_q;
        loaded_q <= 1'b1;
      end
    end
  end

  assign image_o  = img_q;
  assign loaded_o = loaded_q;
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
  parameter int unsigned N_LIT = 32,
  parameter int unsigned N_AND = 64
) (
  input  logic [N_LIT-1:0]       lit_i,
  input  logic [N_AND*N_LIT-1:0] mask_i,
  output logic [N_AND-1:0]       term_o
);
  for (genvar t = 0; t < N_AND; t++) begin : g_term
    // unselected literals read as 1; empty term is true
    assign term_o[t] = &(~mask_i[t*N_LIT +: N_LIT] | lit_i);
  end
endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell #(
  parameter int unsigned N_SUM = 7
) (
  input  logic [N_SUM:0] term_i,  // [N_SUM] is the enable term
  input  logic           pol_i,
  input  logic           loaded_i,
  output logic           val_o,
  output logic           oe_o
);
  logic or_v;

  assign or_v  = |term_i[N_SUM-1:0];
  assign val_o = pol_i ? or_v : ~or_v;
  assign oe_o  = loaded_i & term_i[N_SUM];
endmodule

// File: rtl/pal_feedback_reg.sv
module pal_feedback_reg #(
  parameter int unsigned N_FB = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_FB-1:0] val_i,
  input  logic [N_FB-1:0] oe_i,
  input  logic [N_FB-1:0] pin_i,
  output logic [N_FB-1:0] fb_o
);
  logic [N_FB-1:0] fb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fb_q <= '0;
    else begin
      for (int j = 0; j < int'(N_FB); j++)
        fb_q[j] <= oe_i[j] ? val_i[j] : pin_i[j];
    end
  end

  assign fb_o = fb_q;
endmodule

// File: rtl/pal_logic_device.sv
module pal_logic_device
  import pal_pkg::*;
#(
  parameter int unsigned N_IN  = PAL_N_IN,
  parameter int unsigned N_OUT = PAL_N_OUT,
  parameter int unsigned N_SUM = PAL_N_SUM,
  parameter int unsigned N_FB  = PAL_N_FB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  in_i,
  input  logic [N_FB-1:0]  pin_i,
  input  logic             cfg_bit_i,
  input  logic             cfg_shift_i,
  input  logic             cfg_commit_i,
  output logic [N_OUT-1:0] out_o,
  output logic [N_OUT-1:0] oe_o
);
  localparam int unsigned N_ARR  = N_IN + N_FB;
  localparam int unsigned N_LIT  = 2 * N_ARR;
  localparam int unsigned TPO    = N_SUM + 1;
  localparam int unsigned N_AND  = N_OUT * TPO;
  localparam int unsigned MASK_W = N_AND * N_LIT;
  localparam int unsigned CFG_W  = MASK_W + N_OUT;

  logic [CFG_W-1:0] image;
  logic             loaded;
  logic [N_FB-1:0]  fb_q;
  logic [N_ARR-1:0] arr_in;
  logic [N_LIT-1:0] lit;
  logic [N_AND-1:0] terms;
  logic [N_OUT-1:0] val, oe;

  pal_cfg_loader #(.CFG_W(CFG_W)) i_loader (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_i    (cfg_bit_i),
    .shift_i  (cfg_shift_i),
    .commit_i (cfg_commit_i),
    .image_o  (image),
    .loaded_o (loaded)
  );

  // R7: dedicated inputs low, feedback lines high
  assign arr_in = {fb_q, in_i};

  for (genvar k = 0; k < N_ARR; k++) begin : g_lit
    assign lit[2*k]   = arr_in[k];
    assign lit[2*k+1] = ~arr_in[k];
  end

  pal_and_plane #(.N_LIT(N_LIT), .N_AND(N_AND)) i_and_plane (
    .lit_i  (lit),
    .mask_i (image[MASK_W-1:0]),
    .term_o (terms)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    pal_out_cell #(.N_SUM(N_SUM)) i_cell (
      .term_i   (terms[o*TPO +: TPO]),
      .pol_i    (image[MASK_W+o]),
      .loaded_i (loaded),
      .val_o    (val[o]),
      .oe_o     (oe[o])
    );
  end

  pal_feedback_reg #(.N_FB(N_FB)) i_fb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .val_i  (val[N_FB-1:0]),
    .oe_i   (oe[N_FB-1:0]),
    .pin_i  (pin_i),
    .fb_o   (fb_q)
  );

  assign out_o = val;
  assign oe_o  = oe;
endmodule

// File: rtl/pal_logic_device_chk.sv
module pal_logic_device_chk #(
  parameter int unsigned N_IN  = 10,
  parameter int unsigned N_OUT = 8,
  parameter int unsigned N_FB  = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_commit_i,
  input logic [N_IN-1:0]  in_i,
  input logic [N_FB-1:0]  pin_i,
  input logic [N_OUT-1:0] out_o,
  input logic [N_OUT-1:0] oe_o,
  input logic [N_FB-1:0]  fb_q
);
  logic started_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      started_q <= 1'b1;
      if (cfg_commit_i) seen_q <= 1'b1;
    end
  end

  AST_OE_HELD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> oe_o == '0); // R1

  AST_NO_COMMIT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !$past(cfg_commit_i) && $stable(in_i) && $stable(fb_q))
      |-> ($stable(out_o) && $stable(oe_o))); // R2

  for (genvar j = 0; j < N_FB; j++) begin : g_fb
    AST_FB_OWN_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (started_q && $past(oe_o[j])) |-> fb_q[j] == $past(out_o[j])); // R8
    AST_FB_PIN_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (started_q && !$past(oe_o[j])) |-> fb_q[j] == $past(pin_i[j])); // R8
  end

  AST_OUT_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({out_o, oe_o})); // R10
endmodule

bind pal_logic_device pal_logic_device_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .N_FB(N_FB)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_commit_i (cfg_commit_i),
  .in_i         (in_i),
  .pin_i        (pin_i),
  .out_o        (out_o),
  .oe_o         (oe_o),
  .fb_q         (fb_q)
);

// File: tb/test_pal_logic_device.sv
`timescale 1ns/1ps
module test_pal_logic_device;
  localparam int CFG_W = 2056;

  typedef struct packed {
    logic [9:0] in;
    logic [5:0] pin;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{10'h003, 6'h00},
    '{10'h000, 6'h01},
    '{10'h203, 6'h01},
    '{10'h204, 6'h10},
    '{10'h058, 6'h11},
    '{10'h150, 6'h00},
    '{10'h1FF, 6'h3F},
    '{10'h08A, 6'h2E}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] in_v = '0;
  logic [5:0] pin_v = '0;
  logic       cfg_bit = 1'b0, cfg_shift = 1'b0, cfg_commit = 1'b0;
  logic [7:0] out_w, oe_w;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pal_logic_device i_pal_logic_device (
    .clk_i(clk), .rst_ni(rst_n), .in_i(in_v), .pin_i(pin_v),
    .cfg_bit_i(cfg_bit), .cfg_shift_i(cfg_shift), .cfg_commit_i(cfg_commit),
    .out_o(out_w), .oe_o(oe_w)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lit(int k, int neg);
    return 32'(1) << (2*k + neg);
  endfunction

  // R3 layout: term (o,t) mask at [(o*8+t)*32 +: 32]; R4 polarity at 2048+o
  function automatic logic [CFG_W-1:0] cfg_a();
    logic [CFG_W-1:0] img = '0;
    logic [31:0] never = lit(0,0) | lit(0,1);
    for (int o = 0; o < 8; o++)
      for (int t = 0; t < 7; t++) img[(o*8+t)*32 +: 32] = never;
    img[(0*8+0)*32 +: 32] = lit(0,0) | lit(1,0);
    img[(0*8+7)*32 +: 32] = lit(9,1);
    img[(1*8+0)*32 +: 32] = lit(2,0);
    img[(1*8+1)*32 +: 32] = lit(3,1);
    img[2048+1] = 1'b1;
    img[(2*8+0)*32 +: 32] = lit(10,0);
    img[2048+2] = 1'b1;
    img[(3*8+0)*32 +: 32] = lit(4,0) | lit(5,1) | lit(6,0);
    img[(4*8+7)*32 +: 32] = never;
    img[(5*8+7)*32 +: 32] = never;
    img[2048+4] = 1'b1;
    img[2048+5] = 1'b1;
    img[(6*8+0)*32 +: 32] = lit(14,0);
    img[2048+6] = 1'b1;
    img[(7*8+3)*32 +: 32] = lit(7,0);
    img[(7*8+7)*32 +: 32] = lit(8,0);
    img[2048+7] = 1'b1;
    return img;
  endfunction

  function automatic void ref_a(input logic [9:0] a, input logic [5:0] p,
                                output logic [7:0] eo, output logic [7:0] eoe);
    logic o0, fb0;
    o0  = ~(a[0] & a[1]);
    fb0 = ~a[9] ? o0 : p[0];
    eo  = {a[7], p[4], 1'b0, 1'b0, ~(a[4] & ~a[5] & a[6]), fb0, a[2] | ~a[3], o0};
    eoe = {a[8], 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, ~a[9]};
  endfunction

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  // R9: image MSB first
  task automatic shift_img(logic [CFG_W-1:0] img);
    for (int i = CFG_W-1; i >= 0; i--) begin
      cfg_bit = img[i]; cfg_shift = 1'b1; edge1();
    end
    cfg_shift = 1'b0; cfg_bit = 1'b0;
  endtask

  task automatic commit();
    cfg_commit = 1'b1; edge1(); cfg_commit = 1'b0;
  endtask

  initial begin
    #600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] eo, eoe;
    logic [CFG_W-1:0] img_b;
    #1;
    chk("R10 reset out", out_w, 8'h00);
    chk("R10 reset oe", oe_w, 8'h00);
    edge1(); rst_n = 1'b1; edge1();

    // R1/R2: fully shifted but uncommitted
    in_v = 10'h0FF; pin_v = 6'h3F;
    shift_img(cfg_a());
    edge1(); #1;
    chk("R1 oe before commit", oe_w, 8'h00);
    chk("R2 out before commit", out_w, 8'h00);
    commit();
    ref_a(in_v, pin_v, eo, eoe);
    chk("R6 oe at commit edge", oe_w, eoe);

    // table walk: R3 R4 R5 R6 R7
    foreach (VECS[i]) begin
      in_v = VECS[i].in; pin_v = VECS[i].pin;
      edge1(); edge1();
      ref_a(in_v, pin_v, eo, eoe);
      chk($sformatf("R3/R4/R5/R7 vec %0d out", i), out_w, eo);
      chk($sformatf("R6 vec %0d oe", i), oe_w, eoe);
    end

    // R8: own-value feedback, one edge latency
    in_v = 10'h003; pin_v = 6'h00; edge1(); edge1();
    chk("R8 settled out0/out2", out_w & 8'h05, 8'h00);
    in_v = 10'h002; #1;
    chk("R4 out0 combinational", out_w & 8'h01, 8'h01);
    chk("R8 out2 before edge", out_w & 8'h04, 8'h00);
    edge1();
    chk("R8 out2 after edge", out_w & 8'h04, 8'h04);

    // R8: disabled pin feeds back pin_i
    in_v = 10'h200; pin_v = 6'h01; edge1();
    chk("R8 pin fed back", out_w & 8'h04, 8'h04);
    pin_v = 6'h00; #1;
    chk("R8 pin before edge", out_w & 8'h04, 8'h04);
    edge1();
    chk("R8 pin after edge", out_w & 8'h04, 8'h00);

    // R2: shift a new image without commit, outputs hold
    img_b = '0; img_b[2048+5] = 1'b1;
    in_v = 10'h003; pin_v = 6'h10; edge1(); edge1();
    shift_img(img_b);
    #1;
    ref_a(in_v, pin_v, eo, eoe);
    chk("R2 out after shift", out_w, eo);
    chk("R2 oe after shift", oe_w, eoe);
    commit();
    chk("R9 order out", out_w, 8'h20);
    chk("R3 empty enable", oe_w, 8'hFF);

    // R10: reset clears everything, R1 enables held again
    rst_n = 1'b0; #1;
    chk("R10 async reset out", out_w, 8'h00);
    chk("R10 async reset oe", oe_w, 8'h00);
    edge1(); rst_n = 1'b1; edge1(); edge1();
    chk("R1 oe after reset", oe_w, 8'h00);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule